// File: doc/BRIEF.md
# Partial Reconfiguration Host Port

This block is a register slave placed between a host bus and a configuration engine. The host opens a reconfiguration session by setting a start bit in a control/status register. It then pushes the bitstream as a series of 32-bit writes into a data register. Every data word accepted during a session is passed on, unmodified, to the engine over a valid/ready stream. When the outgoing stream cannot take a word, the bus write is held off with a wait signal.

The engine closes the session with a one-cycle done pulse and a 2-bit result. The block turns that result into a 3-bit session code, which it holds until the host starts a new session. The host polls this code together with the start bit. A final partial word is expected to arrive from the host with its unused upper bytes already zero. The block does not treat it in any special way.

Top module: `pr_cfg_port`

## Requirements
- R1: After reset the control/status register (byte offset 0x04) reads 0, with start bit 0 and status field 0, and the outgoing stream valid is low.
- R2: A write to offset 0x04 with bit 0 set while no session is active starts a session. The register then reads start bit 0 = 1 and status bits 4:2 = 4 (value 0x11).
- R3: While a session is active, a write to offset 0x04 has no effect, whether bit 0 is set or clear. The register keeps reading 0x11.
- R4: Each word written to offset 0x00 during a session is delivered on the stream exactly once, in write order and with all 32 bits unchanged. This includes zero-padded partial words.
- R5: While a forwarded word is waiting and the stream is not ready, the stream data and valid hold steady. A further data write sees bus_wait high until the stream accepts.
- R6: A data write while no session has ever been started is dropped. No word appears on the stream and bus_wait stays low.
- R7: A done pulse during a session ends it and clears the start bit. Result 0 gives status 5, result 1 gives status 1, result 2 gives status 2 and result 3 gives status 3. Status never takes the values 6 or 7.
- R8: An end status stays latched across later polls until the next start write, which sets the status back to 4.
- R9: A done pulse while no session is active leaves the register value unchanged.
- R10: After a session ends in error, later data writes are dropped without wait. A word still pending on the stream at that point is withdrawn and never delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 4 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, held while bus_wait is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| bus_wait | output | 1 | Stalls the current data write |
| cfg_data | output | 32 | Bitstream word to the engine |
| cfg_valid | output | 1 | cfg_data holds a word |
| cfg_ready | input | 1 | Engine takes the word this cycle |
| eng_done | input | 1 | One-cycle end-of-session pulse |
| eng_result | input | 2 | Result code that comes with eng_done |

## Verification
The hardest case to reach is an error that ends a session while a word is still stuck in the outgoing slot. Producing it needs a session start, then cfg_ready held low during a data write, then a done pulse with a failure code before the stream is released. The bench builds that exact order. It then raises ready and confirms that no further word is delivered. A second stall case keeps a second data write waiting against a full slot, so bus_wait can be observed over several cycles.

// File: rtl/pr_cfg_pkg.sv
`timescale 1ns/1ps
package pr_cfg_pkg;
  localparam int DATA_W   = 32;
  localparam int STAT_W   = 3;
  localparam int RES_W    = 2;
  localparam int IDX_DATA = 0;
  localparam int IDX_CSR  = 1;
  localparam int START_POS = 0;
  localparam int STAT_LSB  = 2;

  typedef enum logic [STAT_W-1:0] {
    ST_IDLE     = 3'd0,
    ST_ERR_GEN  = 3'd1,
    ST_ERR_CRC  = 3'd2,
    ST_ERR_BITS = 3'd3,
    ST_BUSY     = 3'd4,
    ST_DONE     = 3'd5
  } sess_st_e;

  function automatic sess_st_e result_to_st(input logic [RES_W-1:0] res);
    case (res)
      2'd0:    return ST_DONE;
      2'd1:    return ST_ERR_GEN;
      2'd2:    return ST_ERR_CRC;
      default: return ST_ERR_BITS;
    endcase
  endfunction
endpackage

// File: rtl/pr_rst_sync.sv
`timescale 1ns/1ps
module pr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pr_sess_fsm.sv
`timescale 1ns/1ps
module pr_sess_fsm
  import pr_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             eng_done,
  input  logic [RES_W-1:0] eng_result,
  output sess_st_e         status_o,
  output logic             busy_o
);
  sess_st_e st_q, st_d;
  logic     st_en;

  always_comb begin
    st_d  = st_q;
    st_en = 1'b0;
    if (st_q == ST_BUSY) begin
      if (eng_done) begin
        st_d  = result_to_st(eng_result);
        st_en = 1'b1;
      end
    end else if (start_req) begin
      st_d  = ST_BUSY;
      st_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= ST_IDLE;
    else if (st_en) st_q <= st_d;
  end

  assign status_o = st_q;
  assign busy_o   = (st_q == ST_BUSY);

  // R2
  start_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_req) |=> (status_o == ST_BUSY));
  // R3
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_req && !eng_done) |=> (status_o == ST_BUSY));
  // R7
  ok_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && eng_done && eng_result == 2'd0) |=> (status_o == ST_DONE));
  // R7
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o <= ST_DONE));
  // R9
  stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && eng_done && !start_req) |=> $stable(status_o));
endmodule

// File: rtl/pr_word_fwd.sv
`timescale 1ns/1ps
module pr_word_fwd #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sess_busy,
  input  logic              wr_data,
  input  logic [WORD_W-1:0] wdata,
  output logic              bus_wait_o,
  output logic [WORD_W-1:0] cfg_data,
  output logic              cfg_valid,
  input  logic              cfg_ready
);
  logic              vld_q, vld_d;
  logic [WORD_W-1:0] word_q;
  logic              take;

  always_comb begin
    take  = wr_data && sess_busy && (!vld_q || cfg_ready);
    vld_d = vld_q;
    if (!sess_busy)     vld_d = 1'b0;
    else if (take)      vld_d = 1'b1;
    else if (cfg_ready) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word_q <= '0;
    else if (take) word_q <= wdata;
  end

  assign bus_wait_o = wr_data && sess_busy && vld_q && !cfg_ready;
  assign cfg_data   = word_q;
  assign cfg_valid  = vld_q;

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_ready) |=> (!sess_busy || (cfg_valid && $stable(cfg_data))));
  // R6
  fwd_in_sess_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_valid) |-> $past(sess_busy));
endmodule

// File: rtl/pr_cfg_port.sv
`timescale 1ns/1ps
module pr_cfg_port
  import pr_cfg_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_wait,
  output logic [DATA_W-1:0] cfg_data,
  output logic              cfg_valid,
  input  logic              cfg_ready,
  input  logic              eng_done,
  input  logic [RES_W-1:0]  eng_result
);
  localparam int IDX_W = ADDR_W - 2;

  logic             rst_i_n;
  logic [IDX_W-1:0] reg_idx;
  logic             unused_lsb;
  logic             wr_data, wr_csr, start_req, busy;
  sess_st_e         status;

  pr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  assign reg_idx    = bus_addr[ADDR_W-1:2];
  assign unused_lsb = ^bus_addr[1:0];
  assign wr_data    = bus_wr && (reg_idx == IDX_W'(IDX_DATA));
  assign wr_csr     = bus_wr && (reg_idx == IDX_W'(IDX_CSR));
  assign start_req  = wr_csr && bus_wdata[START_POS];

  pr_sess_fsm u_fsm (
    .clk(clk), .rst_n(rst_i_n), .start_req(start_req),
    .eng_done(eng_done), .eng_result(eng_result),
    .status_o(status), .busy_o(busy)
  );

  pr_word_fwd #(.WORD_W(DATA_W)) u_fwd (
    .clk(clk), .rst_n(rst_i_n), .sess_busy(busy),
    .wr_data(wr_data), .wdata(bus_wdata), .bus_wait_o(bus_wait),
    .cfg_data(cfg_data), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready)
  );

  always_comb begin
    bus_rdata = '0;
    if (reg_idx == IDX_W'(IDX_CSR)) begin
      bus_rdata[START_POS]                 = busy;
      bus_rdata[STAT_LSB +: STAT_W]        = status;
    end
  end

  // R10
  no_wait_idle_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (status != ST_BUSY) |-> !bus_wait);
endmodule

// File: tb/pr_cfg_port_test.sv
`timescale 1ns/1ps
module pr_cfg_port_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_wait;
  logic [31:0] cfg_data;
  logic        cfg_valid;
  logic        cfg_ready;
  logic        eng_done;
  logic [1:0]  eng_result;

  always #10 clk = ~clk;

  pr_cfg_port uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_wait(bus_wait),
    .cfg_data(cfg_data), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .eng_done(eng_done), .eng_result(eng_result)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] beats [64];
  int nbeat = 0;

  // {hold ready low, word}
  localparam logic [32:0] VEC [8] = '{
    {1'b0, 32'h1234_5678}, {1'b1, 32'hCAFE_0001}, {1'b0, 32'h0000_00A5},
    {1'b1, 32'h0000_BEEF}, {1'b0, 32'h00C0_FFEE}, {1'b1, 32'hFFFF_FFFF},
    {1'b0, 32'h0000_0000}, {1'b1, 32'h8000_0001}
  };

  always @(posedge clk) begin
    if (rst_n && cfg_valid && cfg_ready && nbeat < 64) begin
      beats[nbeat] = cfg_data;
      nbeat = nbeat + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csr_rd(output logic [31:0] v);
    @(negedge clk);
    bus_addr = 4'h4; bus_wr = 1'b0;
    #1 v = bus_rdata;
  endtask

  task automatic csr_wr(input logic [31:0] d);
    @(negedge clk);
    bus_addr = 4'h4; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic data_wr(input logic [31:0] d, output bit waited);
    waited = 1'b0;
    @(negedge clk);
    bus_addr = 4'h0; bus_wr = 1'b1; bus_wdata = d;
    #1;
    while (bus_wait) begin
      waited = 1'b1;
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic done(input logic [1:0] r);
    @(negedge clk);
    eng_done = 1'b1; eng_result = r;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    bit w;
    int base;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    cfg_ready = 1'b1; eng_done = 1'b0; eng_result = '0;
    repeat (3) @(negedge clk);
    csr_rd(v);
    chk(v == 32'h0, "R1 csr", v, 32'h0);
    chk(cfg_valid == 1'b0, "R1 valid", {31'b0, cfg_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    csr_rd(v);
    chk(v == 32'h0, "R1 csr after release", v, 32'h0);

    // R6: data before any session
    data_wr(32'hDEAD_0001, w);
    chk(!w, "R6 wait", {31'b0, w}, 32'h0);
    repeat (2) @(negedge clk);
    chk(nbeat == 0 && !cfg_valid, "R6 dropped", nbeat, 32'h0);

    // R2 start
    csr_wr(32'h1);
    csr_rd(v);
    chk(v == 32'h11, "R2 start", v, 32'h11);
    // R3 restart and clear attempts ignored
    csr_wr(32'h1);
    csr_rd(v);
    chk(v == 32'h11, "R3 restart", v, 32'h11);
    csr_wr(32'h0);
    csr_rd(v);
    chk(v == 32'h11, "R3 clear write", v, 32'h11);

    // R4 / R5 vector walk
    base = nbeat;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      cfg_ready = !VEC[i][32];
      data_wr(VEC[i][31:0], w);
      if (VEC[i][32]) begin
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          #1 chk(cfg_valid && cfg_data == VEC[i][31:0], "R5 hold", cfg_data, VEC[i][31:0]);
        end
        cfg_ready = 1'b1;
      end
    end
    repeat (2) @(negedge clk);
    chk(nbeat - base == 8, "R4 beat count", nbeat - base, 32'd8);
    for (int i = 0; i < 8; i++)
      chk(beats[base + i] == VEC[i][31:0], "R4 word", beats[base + i], VEC[i][31:0]);

    // R5 bus stall against full slot
    base = nbeat;
    @(negedge clk);
    cfg_ready = 1'b0;
    data_wr(32'hA0A0_A0A0, w);
    @(negedge clk);
    bus_addr = 4'h0; bus_wr = 1'b1; bus_wdata = 32'hB1B1_B1B1;
    #1 chk(bus_wait, "R5 wait", {31'b0, bus_wait}, 32'h1);
    @(negedge clk);
    #1 chk(bus_wait && cfg_data == 32'hA0A0_A0A0, "R5 wait hold", cfg_data, 32'hA0A0_A0A0);
    cfg_ready = 1'b1;
    #1 chk(!bus_wait, "R5 release", {31'b0, bus_wait}, 32'h0);
    @(negedge clk);
    bus_wr = 1'b0;
    #1 chk(cfg_valid && cfg_data == 32'hB1B1_B1B1, "R5 next word", cfg_data, 32'hB1B1_B1B1);
    @(negedge clk);
    chk(nbeat - base == 2 && beats[base] == 32'hA0A0_A0A0 && beats[base+1] == 32'hB1B1_B1B1,
        "R4 stall order", nbeat - base, 32'd2);

    // R7 success, R8 latch
    done(2'd0);
    csr_rd(v);
    chk(v == 32'h14, "R7 success", v, 32'h14);
    repeat (3) @(negedge clk);
    csr_rd(v);
    chk(v == 32'h14, "R8 latched", v, 32'h14);
    csr_wr(32'h1);
    csr_rd(v);
    chk(v == 32'h11, "R8 restart", v, 32'h11);

    // R7 CRC error, R10 dropped data, R9 stray done
    done(2'd2);
    csr_rd(v);
    chk(v == 32'h08, "R7 crc", v, 32'h08);
    base = nbeat;
    data_wr(32'h5555_AAAA, w);
    chk(!w, "R10 no wait", {31'b0, w}, 32'h0);
    repeat (2) @(negedge clk);
    chk(nbeat == base && !cfg_valid, "R10 dropped", nbeat - base, 32'h0);
    done(2'd1);
    csr_rd(v);
    chk(v == 32'h08, "R9 stray done", v, 32'h08);

    csr_wr(32'h1);
    done(2'd3);
    csr_rd(v);
    chk(v == 32'h0C, "R7 bad bits", v, 32'h0C);
    csr_wr(32'h1);
    done(2'd1);
    csr_rd(v);
    chk(v == 32'h04, "R7 general", v, 32'h04);

    // R10 pending word withdrawn on error
    csr_wr(32'h1);
    base = nbeat;
    @(negedge clk);
    cfg_ready = 1'b0;
    data_wr(32'h7777_0000, w);
    done(2'd2);
    @(negedge clk);
    #1 chk(!cfg_valid, "R10 flush", {31'b0, cfg_valid}, 32'h0);
    cfg_ready = 1'b1;
    repeat (2) @(negedge clk);
    chk(nbeat == base, "R10 not delivered", nbeat - base, 32'h0);

    summary();
    $finish;
  end
endmodule